// File: doc/BRIEF.md
# Two-Dimensional and Ring-Buffer DMA Address Sequencer

This block generates the word-address stream for one channel of a 2D DMA engine. It is given a word-aligned start address, an X length, a line pitch and a Y length, all in words. The Y length is the number of lines minus one. The block hands addresses to a downstream mover through a valid/ready handshake. Moving the data, the bus protocol and register decoding are outside its scope.

In rectangle mode (X length non-zero) it walks a block of lines. Each line is X length consecutive words. Each new line begins one pitch above the start of the line before it. After the final word is accepted, the block reports completion and goes idle.

In ring mode (X length zero) it counts upward through an area of pitch × (Y length + 1) words and then wraps to the start. It never stops by itself. The area is treated as two equal halves, and a one-cycle event marks the end of each half. Pause freezes the stream. Abort drops the channel back to idle.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `valid`, `done` and `half_evt` are all low.
- R2: In rectangle mode, the words within one line are X length consecutive addresses. The first of them is the line's start address.
- R3: Line 0 begins at the start address. Line n+1 begins at the start of line n plus the pitch.
- R4: A rectangle transfer issues exactly X length × (Y length + 1) addresses. A Y length of 0 gives a single line.
- R5: `done` is high for exactly one cycle, in the cycle after the final rectangle address is accepted. In that same cycle `valid` is already low.
- R6: `addr` changes only after a cycle in which both `valid` and `ready` were high. While `valid` is high and `ready` is low, it holds.
- R7: While `pause` is high, `valid` is low and `addr` is frozen. Once `pause` drops, the stream resumes with the same address.
- R8: One cycle after `abort` is seen, `valid` is low. No `done` pulse follows an abort.
- R9: A `start` that arrives while the block is busy is ignored. The running transfer continues with its original settings.
- R10: When X length is 0 at `start`, the k-th accepted address is start + (k mod A), where A = pitch × (Y length + 1).
- R11: In ring mode, `half_evt` pulses for one cycle right after the accepted word at area position A/2−1 and again at A−1. That gives two pulses per lap.
- R12: Ring mode never raises `done`. It keeps issuing addresses until aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin a transfer with the cfg_* values; only taken when idle |
| cfg_addr | input | AW | Start word address |
| cfg_xlen | input | LW | Words per line; 0 selects ring mode |
| cfg_width | input | LW | Line pitch in words |
| cfg_ylen | input | LW | Number of lines minus one |
| abort | input | 1 | Return to idle on the next cycle |
| pause | input | 1 | Hold valid low and freeze the address |
| ready | input | 1 | Consumer accepts the current address |
| addr | output | AW | Current word address |
| valid | output | 1 | addr is offered to the consumer |
| done | output | 1 | One-cycle pulse after the final rectangle word |
| half_evt | output | 1 | One-cycle pulse after the last word of each ring half |

## Verification
The assertions assume a ring area that is even and at least 2 words, so that both half boundaries exist. For rectangles they assume an X length no larger than the pitch. They also assume the cfg_* inputs matter only in the cycle `start` is taken. All stimulus uses ring settings with an even area of 6 or 8 words and rectangles whose pitch is never below X length. Configuration inputs are changed only while the block is busy, to show they are ignored then.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECT = 2'd1,
    ST_RING = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dma2d_rst_sync.sv
module dma2d_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = stg_q[STAGES-1];
endmodule

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl import dma2d_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic       fire,
  input  logic       ring_sel,
  input  logic       rect_last,
  output seq_state_e state,
  output logic       load,
  output logic       done
);
  seq_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start && !abort) begin
          load    = 1'b1;
          state_d = ring_sel ? ST_RING : ST_RECT;
        end
      end
      ST_RECT: begin
        if (abort) begin
          state_d = ST_IDLE;
        end else if (fire && rect_last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      ST_RING: begin
        if (abort) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign state = state_q;
  assign done  = done_q;
endmodule

// File: rtl/dma2d_rect_walk.sv
module dma2d_rect_walk #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] cfg_addr,
  input  logic [LW-1:0] cfg_xlen,
  input  logic [LW-1:0] cfg_width,
  input  logic [LW-1:0] cfg_ylen,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [AW-1:0] cur_q, cur_d, base_q, base_d;
  logic [LW-1:0] xc_q, xc_d, yc_q, yc_d;
  logic [LW-1:0] xl_q, wd_q, yl_q;
  logic          x_end, adv_en;

  assign x_end  = (xc_q == (xl_q - 1'b1));
  assign last   = x_end && (yc_q == yl_q);
  assign adv_en = load | (step & ~last);

  always_comb begin
    cur_d  = cur_q;
    base_d = base_q;
    xc_d   = xc_q;
    yc_d   = yc_q;
    if (load) begin
      cur_d  = cfg_addr;
      base_d = cfg_addr;
      xc_d   = '0;
      yc_d   = '0;
    end else if (x_end) begin
      base_d = base_q + AW'(wd_q);
      cur_d  = base_d;
      xc_d   = '0;
      yc_d   = yc_q + 1'b1;
    end else begin
      cur_d  = cur_q + 1'b1;
      xc_d   = xc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      base_q <= '0;
      xc_q   <= '0;
      yc_q   <= '0;
    end else if (adv_en) begin
      cur_q  <= cur_d;
      base_q <= base_d;
      xc_q   <= xc_d;
      yc_q   <= yc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_q <= '0;
      wd_q <= '0;
      yl_q <= '0;
    end else if (load) begin
      xl_q <= cfg_xlen;
      wd_q <= cfg_width;
      yl_q <= cfg_ylen;
    end
  end

  assign addr = cur_q;
endmodule

// File: rtl/dma2d_ring_walk.sv
module dma2d_ring_walk #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] cfg_addr,
  input  logic [LW-1:0] cfg_width,
  input  logic [LW-1:0] cfg_ylen,
  output logic [AW-1:0] addr,
  output logic          evt
);
  localparam int PW = 2 * LW + 1;

  logic [AW-1:0] cur_q, cur_d, base_q;
  logic [PW-1:0] pos_q, pos_d, alast_q, hlast_q;
  logic [PW-1:0] area_w, alast_d, hlast_d;
  logic          wrap, adv_en;

  assign area_w  = PW'(cfg_width) * (PW'(cfg_ylen) + PW'(1));
  assign alast_d = area_w - PW'(1);
  assign hlast_d = (area_w >> 1) - PW'(1);

  assign wrap   = (pos_q == alast_q);
  assign evt    = step & ((pos_q == hlast_q) | wrap);
  assign adv_en = load | step;

  always_comb begin
    if (load) begin
      cur_d = cfg_addr;
      pos_d = '0;
    end else if (wrap) begin
      cur_d = base_q;
      pos_d = '0;
    end else begin
      cur_d = cur_q + 1'b1;
      pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      pos_q <= '0;
    end else if (adv_en) begin
      cur_q <= cur_d;
      pos_q <= pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      alast_q <= '0;
      hlast_q <= '0;
    end else if (load) begin
      base_q  <= cfg_addr;
      alast_q <= alast_d;
      hlast_q <= hlast_d;
    end
  end

  assign addr = cur_q;
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen import dma2d_pkg::*; #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_addr,
  input  logic [LW-1:0] cfg_xlen,
  input  logic [LW-1:0] cfg_width,
  input  logic [LW-1:0] cfg_ylen,
  input  logic          abort,
  input  logic          pause,
  input  logic          ready,
  output logic [AW-1:0] addr,
  output logic          valid,
  output logic          done,
  output logic          half_evt
);
  logic          rst_n_i;
  seq_state_e    state;
  logic          load, fire, busy, ring_sel;
  logic          rect_last, rect_step, ring_step, ring_evt;
  logic          ring_mode_q, half_q, half_d;
  logic [AW-1:0] rect_addr, ring_addr;

  dma2d_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign ring_sel  = (cfg_xlen == '0);
  assign busy      = (state != ST_IDLE);
  assign valid     = busy & ~pause;
  assign fire      = valid & ready;
  assign rect_step = fire & (state == ST_RECT);
  assign ring_step = fire & (state == ST_RING);

  dma2d_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .start     (start),
    .abort     (abort),
    .fire      (fire),
    .ring_sel  (ring_sel),
    .rect_last (rect_last),
    .state     (state),
    .load      (load),
    .done      (done)
  );

  dma2d_rect_walk #(.AW(AW), .LW(LW)) u_rect (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .load      (load),
    .step      (rect_step),
    .cfg_addr  (cfg_addr),
    .cfg_xlen  (cfg_xlen),
    .cfg_width (cfg_width),
    .cfg_ylen  (cfg_ylen),
    .addr      (rect_addr),
    .last      (rect_last)
  );

  dma2d_ring_walk #(.AW(AW), .LW(LW)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .load      (load),
    .step      (ring_step),
    .cfg_addr  (cfg_addr),
    .cfg_width (cfg_width),
    .cfg_ylen  (cfg_ylen),
    .addr      (ring_addr),
    .evt       (ring_evt)
  );

  assign half_d = ring_evt & ~abort;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) ring_mode_q <= 1'b0;
    else if (load) ring_mode_q <= ring_sel;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) half_q <= 1'b0;
    else          half_q <= half_d;
  end

  assign half_evt = half_q;
  assign addr     = ring_mode_q ? ring_addr : rect_addr;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort,
  input logic          pause,
  input logic          ready,
  input logic [AW-1:0] addr,
  input logic          valid,
  input logic          done,
  input logic          half_evt
);
  AST_PAUSE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pause |-> !valid); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> $stable(addr)); // R6

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!valid && !done)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(valid && ready)); // R5

  AST_HALF_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    half_evt |-> $past(valid && ready)); // R11

  AST_DONE_HALF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !half_evt); // R12
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .abort    (abort),
  .pause    (pause),
  .ready    (ready),
  .addr     (addr),
  .valid    (valid),
  .done     (done),
  .half_evt (half_evt)
);

// File: tb/dma2d_addr_gen_tb.sv
`timescale 1ns/1ps
module dma2d_addr_gen_tb;
  localparam int AW = 16;
  localparam int LW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [LW-1:0] cfg_xlen = '0;
  logic [LW-1:0] cfg_width = '0;
  logic [LW-1:0] cfg_ylen = '0;
  logic          abort = 1'b0;
  logic          pause = 1'b0;
  logic          ready = 1'b0;
  logic [AW-1:0] addr;
  logic          valid, done, half_evt;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dma2d_addr_gen #(.AW(AW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_addr(cfg_addr),
    .cfg_xlen(cfg_xlen), .cfg_width(cfg_width), .cfg_ylen(cfg_ylen),
    .abort(abort), .pause(pause), .ready(ready),
    .addr(addr), .valid(valid), .done(done), .half_evt(half_evt)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit rdy_pat(input int cyc, input int m);
    if (m == 0) return 1'b1;
    if (m == 1) return (cyc % 3) != 1;
    return ((cyc * 7 + 3) % 5) < 3;
  endfunction

  // Rectangle run; pm adds a pause window (R7), sm a start while busy (R9)
  task automatic run_rect(input int b, input int x, input int w, input int y,
                          input int rm, input int pm, input int sm);
    int k = 0;
    int total = x * (y + 1);
    int cyc = 0;
    int ea;
    bit hold = 0;
    logic [AW-1:0] held = '0;
    cfg_addr = AW'(b); cfg_xlen = LW'(x); cfg_width = LW'(w); cfg_ylen = LW'(y);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (k < total && cyc < 500) begin
      ready = rdy_pat(cyc, rm);
      pause = (pm != 0) && cyc >= 2 && cyc < 5;
      if (sm != 0 && cyc == 1) begin
        start = 1'b1; cfg_addr = AW'(b + 1024); cfg_xlen = LW'(x + 1); cfg_ylen = '0;
      end else begin
        start = 1'b0; cfg_addr = AW'(b); cfg_xlen = LW'(x); cfg_ylen = LW'(y);
      end
      #1;
      if (hold) chk(addr == held, pause ? "R7" : "R6", addr, held);
      if (pause) chk(!valid, "R7", valid, 0);
      chk(!done, "R5", done, 0);
      hold = 0;
      if (valid && ready) begin
        ea = b + (k / x) * w + (k % x);
        chk(addr == AW'(ea), (k % x == 0) ? ((sm != 0) ? "R9" : "R3") : "R2", addr, ea);
        k++;
      end else begin
        hold = 1; held = addr;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; pause = 1'b0; ready = 1'b0;
    #1;
    chk(k == total, "R4", k, total);
    chk(done && !valid, "R5", {done, valid}, 2);
    @(negedge clk);
    #1;
    chk(!done && !valid, "R5", {done, valid}, 0);
  endtask

  // Ring run for nf accepted words, then abort (R8, R10, R11, R12)
  task automatic run_ring(input int b, input int w, input int y, input int nf, input int rm);
    int area = w * (y + 1);
    int half = area / 2;
    int k = 0;
    int cyc = 0;
    int ea;
    bit exph = 0;
    cfg_addr = AW'(b); cfg_xlen = '0; cfg_width = LW'(w); cfg_ylen = LW'(y);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (k < nf && cyc < 1000) begin
      ready = rdy_pat(cyc, rm);
      #1;
      chk(half_evt == exph, "R11", half_evt, exph);
      chk(!done, "R12", done, 0);
      exph = 0;
      if (valid && ready) begin
        ea = b + (k % area);
        chk(addr == AW'(ea), "R10", addr, ea);
        exph = (k % half) == (half - 1);
        k++;
      end
      @(negedge clk);
      cyc++;
    end
    ready = 1'b0;
    abort = 1'b1;
    #1;
    chk(half_evt == exph, "R11", half_evt, exph);
    chk(valid, "R12", valid, 1);
    @(negedge clk);
    abort = 1'b0;
    #1;
    chk(!valid && !done, "R8", {valid, done}, 0);
    @(negedge clk);
    #1;
    chk(!valid && !done && !half_evt, "R8", {valid, done, half_evt}, 0);
  endtask

  initial begin
    #1;
    chk(!valid && !done && !half_evt, "R1", {valid, done, half_evt}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!valid && !done && !half_evt, "R1", {valid, done, half_evt}, 0);

    // Sweep of small rectangles under three ready patterns (R2, R3, R4, R5, R6)
    for (int x = 1; x <= 3; x++)
      for (int dw = 0; dw <= 2; dw++)
        for (int y = 0; y <= 2; y++)
          for (int rm = 0; rm <= 2; rm++)
            run_rect(16'h0100 + x * 64, x, x + dw, y, rm, 0, 0);

    // Pause window mid-transfer (R7)
    run_rect(16'h0300, 4, 6, 2, 1, 1, 0);
    run_rect(16'h0340, 3, 3, 3, 0, 1, 0);
    // Start while busy with different settings (R9)
    run_rect(16'h0400, 4, 5, 2, 0, 0, 1);

    // Abort during a rectangle (R8)
    cfg_addr = 16'h0500; cfg_xlen = 6'd3; cfg_width = 6'd4; cfg_ylen = 6'd3;
    start = 1'b1; ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(!valid && !done, "R8", {valid, done}, 0);
      @(negedge clk);
    end
    ready = 1'b0;
    run_rect(16'h0600, 2, 3, 1, 2, 0, 0);

    // Ring mode: area 8 with pitch 1, and area 6 with pitch 3
    run_ring(16'h0700, 1, 7, 20, 0);
    run_ring(16'h0780, 1, 7, 19, 2);
    run_ring(16'h0800, 3, 1, 14, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule